// File: doc/BRIEF.md
# Master Stereo Serial Audio Port

This block is a master-only serial port for an audio codec. It drives the bit clock and the word-select line, shifts one stereo frame out on its data output, and captures one stereo frame from its data input in the same frame. Software-side logic loads a left and a right sample of up to 16 bits, pulses a start command, and waits on a busy flag or a sticky interrupt. When the frame ends, the two captured samples appear on the receive outputs.

Three framing formats are available: standard I2S, where the MSB lags the word-select edge by one bit clock; left-justified; and right-justified. Each channel slot is either exactly the sample size or, with padding on, 16 plus a programmable number of pad bits. The bit clock comes from the system clock through an integer divider. It can stop between frames or run continuously for codecs that use it as a reference. The word-select polarity and its idle level are both selectable.

Top module: `aud_serial_master`

## Requirements
- R1: The bit clock `sck` has high and low phases of `cfg_div`+1 system clocks each while it runs. With `cfg_clk_cont`=0 it is held low whenever `busy` is low.
- R2: With `cfg_clk_cont`=1, `sck` toggles every `cfg_div`+1 system clocks while idle. After a start, the frame's first bit period begins at the first falling edge of `sck`.
- R3: `sdo` and `ws` change only while `sck` is low or at the edge where it falls. `sdi` is sampled at the edge where `sck` rises.
- R4: The left slot is sent before the right slot, MSB first. The sample size S is `cfg_size_m1`+1 (1 to 16), and each sample's bit S-1 is its MSB.
- R5: The slot width W is S when `cfg_pad_en`=0, and 16+P when `cfg_pad_en`=1, where P is `cfg_pad` clamped to 16. A frame has 2W bit periods, plus one more in I2S format.
- R6: `cfg_fmt` encodes the format as 0=I2S, 1=left-justified, 2=right-justified and 3=left-justified. In I2S format, data lags word select by one bit period. In right-justified format, the sample ends on the last bit of the slot and leading bits are 0. In the other formats, bits after the sample are 0.
- R7: During a frame, `ws` shows the right channel for bit periods W to 2W-1 and the left channel otherwise. The left channel is `ws`=0, or `ws`=1 when `cfg_ws_inv`=1.
- R8: Outside frames, `ws` shows the left-channel level when `cfg_idle_left`=1 and the right-channel level when it is 0.
- R9: Transmit data is latched at start. When the frame ends, `rx_left`/`rx_right` take the received samples. Bits outside the sample positions are 0, and bits beyond the sample are dropped.
- R10: `busy` rises on the clock after an accepted start and falls when the frame ends. A start while `busy` is high is ignored, including any new transmit data.
- R11: `irq` sets when a frame ends and stays high until `irq_ack` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 8 | Bit-clock half-period minus one, in system clocks |
| cfg_fmt | input | 2 | Frame format (0 I2S, 1 left, 2 right, 3 left) |
| cfg_size_m1 | input | 4 | Sample size minus one |
| cfg_pad_en | input | 1 | Use padded 16+P slots |
| cfg_pad | input | 5 | Extra pad bits P per slot (clamped to 16) |
| cfg_ws_inv | input | 1 | Left channel is ws=1 |
| cfg_idle_left | input | 1 | Idle ws shows left channel |
| cfg_clk_cont | input | 1 | Keep bit clock running between frames |
| tx_left | input | 16 | Left sample to send |
| tx_right | input | 16 | Right sample to send |
| start | input | 1 | Begin one frame (ignored while busy) |
| irq_ack | input | 1 | Clear the completion interrupt |
| sdi | input | 1 | Serial data from codec |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select |
| sdo | output | 1 | Serial data to codec |
| rx_left | output | 16 | Last received left sample |
| rx_right | output | 16 | Last received right sample |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | Sticky completion interrupt |

## Verification
Frames are run across all four format codes and sizes from 1 to 16. Slots are both unpadded and padded up to 32 bits, and random divider values are used, so a shift in bit alignment between formats or a miscounted slot shows up as wrong bits or a wrong period count. Directed frames pin down the boundaries: a 1-bit sample, a 3-bit sample in a padded slot in both justifications, and a full 16-bit sample in a 32-bit slot, where extra received bits must be dropped. Polarity and idle-level combinations separate the word-select inversion from the idle choice. A start with new transmit data in mid-frame shows whether a busy start is really ignored. A continuous-clock frame checks the alignment to the first falling edge.

// File: rtl/aud_pkg.sv
package aud_pkg;
   typedef enum logic [1:0] {
      FMT_I2S   = 2'd0,
      FMT_LEFT  = 2'd1,
      FMT_RIGHT = 2'd2,
      FMT_ALT   = 2'd3
   } fmt_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARM  = 2'd1,
      ST_RUN  = 2'd2
   } seq_e;
endpackage

// File: rtl/aud_clk_div.sv
module aud_clk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = !clear && (cnt_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clear || tick)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   // R1: a nonzero divider never yields ticks on consecutive clocks
   p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0) |=> (!tick || !$stable(div)));
endmodule

// File: rtl/aud_slot_map.sv
module aud_slot_map
   import aud_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int PAD_MAX  = 16,
   parameter int CNT_W    = 7,
   parameter int SIZE_W   = 4,
   parameter int PAD_W    = 5
) (
   input  logic [CNT_W-1:0]  cnt,
   input  logic [1:0]        fmt,
   input  logic [SIZE_W-1:0] size_m1,
   input  logic              pad_en,
   input  logic [PAD_W-1:0]  pad,
   output logic              ws_right,
   output logic              chan,
   output logic [SIZE_W-1:0] bit_idx,
   output logic              bit_valid,
   output logic [CNT_W-1:0]  last_cnt
);
   fmt_e fmt_t;
   logic [CNT_W-1:0] s, w, len, off, d, pos, padc, rj_rem;
   logic             in_frame;

   assign fmt_t = fmt_e'(fmt);

   always_comb begin
      s        = CNT_W'(size_m1) + CNT_W'(1);
      padc     = (pad > PAD_W'(PAD_MAX)) ? CNT_W'(PAD_MAX) : CNT_W'(pad);
      w        = pad_en ? CNT_W'(SAMPLE_W) + padc : s;
      len      = w << 1;
      off      = (fmt_t == FMT_I2S) ? CNT_W'(1) : '0;
      d        = cnt - off;
      in_frame = (cnt >= off) && (d < len);
      chan     = (d >= w);
      pos      = chan ? d - w : d;
      rj_rem   = w - CNT_W'(1) - pos;
      if (fmt_t == FMT_RIGHT) begin
         bit_valid = in_frame && (rj_rem < s);
         bit_idx   = rj_rem[SIZE_W-1:0];
      end else begin
         bit_valid = in_frame && (pos < s);
         bit_idx   = size_m1 - pos[SIZE_W-1:0];
      end
      ws_right = (cnt >= w) && (cnt < len);
      last_cnt = len + off - CNT_W'(1);
   end
endmodule

// File: rtl/aud_seq.sv
module aud_seq
   import aud_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             clk_cont,
   input  logic             tick,
   input  logic [CNT_W-1:0] last_cnt,
   input  logic             irq_ack,
   output logic             div_clear,
   output logic             accept,
   output logic             run,
   output logic             rise,
   output logic             done,
   output logic             busy,
   output logic             sck,
   output logic             irq,
   output logic [CNT_W-1:0] cnt
);
   seq_e             st_q;
   logic             sck_q, irq_q;
   logic [CNT_W-1:0] cnt_q;

   assign run       = (st_q == ST_RUN);
   assign busy      = (st_q != ST_IDLE);
   assign accept    = start && (st_q == ST_IDLE);
   assign div_clear = !(run || clk_cont);
   assign rise      = run && tick && !sck_q;
   assign done      = run && tick && sck_q && (cnt_q == last_cnt);
   assign sck       = sck_q;
   assign irq       = irq_q;
   assign cnt       = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         sck_q <= 1'b0;
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (clk_cont) begin
                  if (tick) sck_q <= ~sck_q;
               end else begin
                  sck_q <= 1'b0;
               end
               if (start) begin
                  st_q  <= ST_ARM;
                  cnt_q <= '0;
               end
            end
            ST_ARM: begin
               if (!clk_cont) begin
                  sck_q <= 1'b0;
                  st_q  <= ST_RUN;
               end else if (tick) begin
                  sck_q <= ~sck_q;
                  if (sck_q) st_q <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (tick) begin
                  sck_q <= ~sck_q;
                  if (sck_q) begin
                     if (cnt_q == last_cnt) st_q <= ST_IDLE;
                     else                   cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
         if (done)         irq_q <= 1'b1;
         else if (irq_ack) irq_q <= 1'b0;
      end
   end

   p_busy_from_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_ack) |=> irq);
   p_irq_on_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (irq && !busy));
endmodule

// File: rtl/aud_data.sv
module aud_data #(
   parameter int SAMPLE_W = 16,
   parameter int SIZE_W   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                accept,
   input  logic                rise,
   input  logic                done,
   input  logic                run,
   input  logic                sdi,
   input  logic                chan,
   input  logic [SIZE_W-1:0]   bit_idx,
   input  logic                bit_valid,
   input  logic [SAMPLE_W-1:0] tx_left,
   input  logic [SAMPLE_W-1:0] tx_right,
   output logic                sdo,
   output logic [SAMPLE_W-1:0] rx_left,
   output logic [SAMPLE_W-1:0] rx_right
);
   logic [1:0][SAMPLE_W-1:0] tx_in, tx_bus, rx_bus;

   assign tx_in[0] = tx_left;
   assign tx_in[1] = tx_right;

   for (genvar g = 0; g < 2; g++) begin : g_chan
      logic [SAMPLE_W-1:0] tx_q, acc_q, rx_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tx_q  <= '0;
            acc_q <= '0;
            rx_q  <= '0;
         end else begin
            if (accept) begin
               tx_q  <= tx_in[g];
               acc_q <= '0;
            end else if (rise && bit_valid && (chan == 1'(g))) begin
               acc_q[bit_idx] <= sdi;
            end
            if (done) rx_q <= acc_q;
         end
      end
      assign tx_bus[g] = tx_q;
      assign rx_bus[g] = rx_q;
   end

   assign sdo      = run && bit_valid && tx_bus[chan][bit_idx];
   assign rx_left  = rx_bus[0];
   assign rx_right = rx_bus[1];

   p_rx_only_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(rx_bus));
   p_capture_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rise |-> run);
endmodule

// File: rtl/aud_serial_master.sv
module aud_serial_master
   import aud_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int PAD_MAX  = 16,
   parameter int DIV_W    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [DIV_W-1:0]            cfg_div,
   input  logic [1:0]                  cfg_fmt,
   input  logic [$clog2(SAMPLE_W)-1:0] cfg_size_m1,
   input  logic                        cfg_pad_en,
   input  logic [$clog2(PAD_MAX+1)-1:0] cfg_pad,
   input  logic                        cfg_ws_inv,
   input  logic                        cfg_idle_left,
   input  logic                        cfg_clk_cont,
   input  logic [SAMPLE_W-1:0]         tx_left,
   input  logic [SAMPLE_W-1:0]         tx_right,
   input  logic                        start,
   input  logic                        irq_ack,
   input  logic                        sdi,
   output logic                        sck,
   output logic                        ws,
   output logic                        sdo,
   output logic [SAMPLE_W-1:0]         rx_left,
   output logic [SAMPLE_W-1:0]         rx_right,
   output logic                        busy,
   output logic                        irq
);
   localparam int SIZE_W   = $clog2(SAMPLE_W);
   localparam int PAD_W    = $clog2(PAD_MAX + 1);
   localparam int SLOT_MAX = SAMPLE_W + PAD_MAX;
   localparam int CNT_W    = $clog2(2 * SLOT_MAX + 2);

   if (SAMPLE_W < 2 || (SAMPLE_W & (SAMPLE_W - 1)) != 0) begin : g_bad_sample
      $error("SAMPLE_W must be a power of two of at least 2");
   end
   if (PAD_MAX < 0 || DIV_W < 1) begin : g_bad_cfg
      $error("PAD_MAX must be non-negative and DIV_W positive");
   end

   logic             tick, div_clear, accept, run, rise, done;
   logic             ws_right, chan, bit_valid;
   logic [SIZE_W-1:0] bit_idx;
   logic [CNT_W-1:0] cnt, last_cnt;

   aud_clk_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .clear(div_clear), .div(cfg_div), .tick(tick)
   );

   aud_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .clk_cont(cfg_clk_cont),
      .tick(tick), .last_cnt(last_cnt), .irq_ack(irq_ack),
      .div_clear(div_clear), .accept(accept), .run(run), .rise(rise),
      .done(done), .busy(busy), .sck(sck), .irq(irq), .cnt(cnt)
   );

   aud_slot_map #(
      .SAMPLE_W(SAMPLE_W), .PAD_MAX(PAD_MAX), .CNT_W(CNT_W),
      .SIZE_W(SIZE_W), .PAD_W(PAD_W)
   ) u_map (
      .cnt(cnt), .fmt(cfg_fmt), .size_m1(cfg_size_m1), .pad_en(cfg_pad_en),
      .pad(cfg_pad), .ws_right(ws_right), .chan(chan), .bit_idx(bit_idx),
      .bit_valid(bit_valid), .last_cnt(last_cnt)
   );

   aud_data #(.SAMPLE_W(SAMPLE_W), .SIZE_W(SIZE_W)) u_data (
      .clk(clk), .rst_n(rst_n), .accept(accept), .rise(rise), .done(done),
      .run(run), .sdi(sdi), .chan(chan), .bit_idx(bit_idx),
      .bit_valid(bit_valid), .tx_left(tx_left), .tx_right(tx_right),
      .sdo(sdo), .rx_left(rx_left), .rx_right(rx_right)
   );

   // left level is cfg_ws_inv, right level its complement
   assign ws = run ? (ws_right ^ cfg_ws_inv)
                   : (cfg_idle_left ? cfg_ws_inv : !cfg_ws_inv);

   p_sdo_hold_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(sdo));
   p_ws_hold_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && sck && $past(sck)) |-> $stable(ws));
   p_idle_clock_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cfg_clk_cont) |=> (!sck || busy));
endmodule

// File: tb/aud_serial_master_tb.sv
`timescale 1ns/1ps
module aud_serial_master_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_div = '0;
   logic [1:0]  cfg_fmt = '0;
   logic [3:0]  cfg_size_m1 = 4'd15;
   logic        cfg_pad_en = 1'b0;
   logic [4:0]  cfg_pad = '0;
   logic        cfg_ws_inv = 1'b0, cfg_idle_left = 1'b0, cfg_clk_cont = 1'b0;
   logic [15:0] tx_left = '0, tx_right = '0;
   logic        start = 1'b0, irq_ack = 1'b0, sdi = 1'b0;
   logic        sck, ws, sdo, busy, irq;
   logic [15:0] rx_left, rx_right;

   int n_total = 0, n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   aud_serial_master u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_fmt(cfg_fmt),
      .cfg_size_m1(cfg_size_m1), .cfg_pad_en(cfg_pad_en), .cfg_pad(cfg_pad),
      .cfg_ws_inv(cfg_ws_inv), .cfg_idle_left(cfg_idle_left),
      .cfg_clk_cont(cfg_clk_cont), .tx_left(tx_left), .tx_right(tx_right),
      .start(start), .irq_ack(irq_ack), .sdi(sdi), .sck(sck), .ws(ws),
      .sdo(sdo), .rx_left(rx_left), .rx_right(rx_right), .busy(busy), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // bit-period k -> which sample bit is on the line
   function automatic void exp_map(input int k, input int fmt, input int s, input int w,
                                   output bit v, output int ch, output int idx);
      int off, d, pos;
      off = (fmt == 0) ? 1 : 0;
      d = k - off;
      v = 0; ch = 0; idx = 0;
      if (d < 0 || d >= 2 * w) return;
      ch  = (d >= w) ? 1 : 0;
      pos = d - ch * w;
      if (fmt == 2) begin
         if (pos >= w - s) begin v = 1; idx = w - 1 - pos; end
      end else if (pos < s) begin
         v = 1; idx = s - 1 - pos;
      end
   endfunction

   task automatic run_frame(input int fmt, input int sz, input int pe, input int pd,
                            input int inv, input int il, input int cont, input int dv,
                            input logic [15:0] tl, input logic [15:0] tr, input bit mid);
      bit rnd [0:71];
      bit cap_sdo [0:71];
      bit cap_ws [0:71];
      int w, n, k, cyc, hi, bad_sdo, bad_ws, ch, idx;
      bit started, prev, meas, v, did_mid, exp_b, exp_w;
      logic [15:0] el, er;
      for (int i = 0; i < 72; i++) rnd[i] = 1'($urandom);
      w = pe ? 16 + ((pd > 16) ? 16 : pd) : sz;
      n = 2 * w + ((fmt == 0) ? 1 : 0);
      @(negedge clk);
      cfg_fmt = 2'(fmt); cfg_size_m1 = 4'(sz - 1); cfg_pad_en = 1'(pe);
      cfg_pad = 5'(pd); cfg_ws_inv = 1'(inv); cfg_idle_left = 1'(il);
      cfg_clk_cont = 1'(cont); cfg_div = 8'(dv);
      tx_left = tl; tx_right = tr; sdi = rnd[0];
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R10", "busy after start", busy, 1);
      prev = sck; started = !cont; k = 0; cyc = 0; hi = 0; meas = 0; did_mid = 0;
      while (busy && cyc < 5000) begin
         if (mid && k == 3 && !did_mid) begin
            did_mid = 1; start = 1'b1; tx_left = ~tl; tx_right = ~tr;
         end
         @(negedge clk);
         cyc++;
         start = 1'b0;
         if (!started) begin
            if (prev && !sck) started = 1;
         end else begin
            if (!prev && sck && k < 72) begin
               cap_sdo[k] = sdo; cap_ws[k] = ws; k++;
               if (k < 72) sdi = rnd[k];
            end
            if (sck) hi++;
            if (prev && !sck && hi > 0 && !meas) begin
               meas = 1;
               chk(hi == dv + 1, "R1", "high phase length", hi, dv + 1);
            end
         end
         prev = sck;
      end
      chk(cyc < 5000, "R10", "frame completion", cyc, 5000);
      chk(k == n, "R5", "bit periods per frame", k, n);
      bad_sdo = 0; bad_ws = 0; el = '0; er = '0;
      for (int i = 0; i < k && i < n; i++) begin
         exp_map(i, fmt, sz, w, v, ch, idx);
         exp_b = v ? (ch ? tr[idx] : tl[idx]) : 1'b0;
         if (cap_sdo[i] !== exp_b) bad_sdo++;
         exp_w = ((i >= w) && (i < 2 * w)) ? !inv[0] : inv[0];
         if (cap_ws[i] !== exp_w) bad_ws++;
         if (v) begin
            if (ch == 1) er[idx] = rnd[i];
            else         el[idx] = rnd[i];
         end
      end
      chk(bad_sdo == 0, mid ? "R10" : "R4 R6", "sdo bit mismatches", bad_sdo, 0);
      chk(bad_ws == 0, "R7", "ws mismatches", bad_ws, 0);
      chk(rx_left === el, "R9", "rx_left", rx_left, el);
      chk(rx_right === er, "R9", "rx_right", rx_right, er);
      chk(irq === 1'b1, "R11", "irq at end", irq, 1);
      chk(ws === ((il != 0) ? inv[0] : !inv[0]), "R8", "idle ws", ws, (il != 0) ? inv : 1 - inv);
      if (!cont) chk(sck === 1'b0, "R1", "idle sck", sck, 0);
      repeat (3) @(negedge clk);
      chk(irq === 1'b1, "R11", "irq held", irq, 1);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      chk(irq === 1'b0, "R11", "irq after ack", irq, 0);
   endtask

   initial begin
      #1_200_000;
      if (!finished) begin
         n_total++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin
      int t;
      t = $urandom(32'h5EED);
      repeat (3) @(negedge clk);
      chk(sck === 1'b0 && busy === 1'b0 && irq === 1'b0, "R1", "reset sck/busy/irq",
          {sck, busy, irq}, 0);
      chk(rx_left === 16'h0 && rx_right === 16'h0, "R9", "reset rx", {rx_left, rx_right}, 0);
      chk(ws === 1'b1, "R8", "reset idle ws right", ws, 1);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corners
      run_frame(0, 16, 0, 0, 0, 0, 0, 0, 16'hA5C3, 16'h3C5A, 0); // R6 I2S
      run_frame(1, 3, 1, 5, 0, 0, 0, 1, 16'h0005, 16'h0003, 0);  // R5 padded LJ
      run_frame(2, 3, 1, 5, 0, 0, 0, 1, 16'h0005, 16'h0006, 0);  // R6 padded RJ
      run_frame(1, 16, 1, 16, 0, 0, 0, 0, 16'hFFFF, 16'h8001, 0); // R9 discard past 16
      run_frame(2, 16, 1, 16, 1, 1, 0, 0, 16'h1234, 16'hFEDC, 0); // R7 R8 inverted
      run_frame(3, 1, 0, 0, 1, 0, 0, 2, 16'h0001, 16'h0000, 0);   // R4 1-bit sample
      run_frame(1, 8, 0, 0, 0, 1, 0, 1, 16'h00C3, 16'h005A, 1);   // R10 busy start
      run_frame(0, 12, 1, 2, 0, 0, 1, 2, 16'h0ABC, 16'h0123, 0);  // R2 continuous
      // R2 continuous toggling while idle
      begin
         int tog; bit p;
         cfg_clk_cont = 1'b1; cfg_div = 8'd2;
         repeat (5) @(negedge clk);
         p = sck; tog = 0;
         for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (sck !== p) tog++;
            p = sck;
         end
         chk(tog == 20, "R2", "idle toggles", tog, 20);
         cfg_clk_cont = 1'b0;
         repeat (2) @(negedge clk);
         tog = 0;
         for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (sck !== 1'b0) tog++;
         end
         chk(tog == 0, "R1", "sck low after continuous off", tog, 0);
      end
      // constrained random frames
      for (int r = 0; r < 24; r++) begin
         run_frame(int'($urandom_range(3, 0)), int'($urandom_range(16, 1)),
                   int'($urandom_range(1, 0)), int'($urandom_range(16, 0)),
                   int'($urandom_range(1, 0)), int'($urandom_range(1, 0)),
                   ($urandom_range(3, 0) == 0) ? 1 : 0, int'($urandom_range(3, 0)),
                   16'($urandom), 16'($urandom), 0);
      end
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end
endmodule